// File: doc/BRIEF.md
# Codec Control Reset Sequencer and Register Port

This block sits in front of a mono codec's control logic. It owns the reset lockout and the bank of control registers. When the reset pin is held low, every control register goes back to its default value. The sample-memory clear strobe is raised, and the serial data pin is watched so that the master or slave choice can be latched. Once the pin is released, a counter keeps the block busy for a fixed number of master-clock periods. During that time no programming takes effect.

After the lockout ends, a host shifts 16-bit control words in over the serial port. Each word starts at a bit-clock rising edge that sees the frame sync high. A word carries a write flag, a three-bit register address and a ten-bit data field. Writes update one of seven ten-bit registers; one register (index 5) is read-only. A read loads the addressed register into a return word, and that word is shifted out on the serial output during the next frame.

All serial pins are brought into the master-clock domain through synchronizer stages, so the bit clock must be several times slower than the master clock. All register contents are exported in parallel for the rest of the codec.

Top module: `codec_ctl_top`

## Requirements
- R1: While `rst_n` is low, `busy` and `mem_clear` are high and register n holds its default value n×64 (so 0, 64, 128, 192, 256, 320, 384), found at `reg_data[10n+9:10n]`.
- R2: After `rst_n` rises, `busy` and `mem_clear` stay high for exactly RESET_CYCLES (3072) rising master-clock edges and then go low together.
- R3: `master_mode` takes the level of `sdi` last seen while `rst_n` is low, and holds it unchanged while `rst_n` is high.
- R4: A word starts at the `sclk` rising edge where `fsync` is high, and 16 bits are taken MSB first, one per `sclk` rising edge. The bit fields are: bit 15 = write flag (1 = write, 0 = read), bits 14:12 = address, bits 11:10 = reserved and ignored, bits 9:0 = data.
- R5: A write to address 0, 1, 2, 3, 4 or 6 sets that register to the data field and leaves every other register unchanged.
- R6: A write to address 5 (the read-only register) changes no register.
- R7: A write to address 7 changes no register.
- R8: A read of address 0 to 6 returns that register in the next frame on `sdo`, MSB first, one bit after each `sclk` rising edge. The return word is 16 bits with the register in bits 9:0 and bits 15:10 zero. The read word's data field changes no register.
- R9: A read of address 7 returns an all-zero word in the next frame.
- R10: A word that completes while `busy` is high changes no register and produces no read return.
- R11: In a frame that does not follow an accepted read, `sdo` is zero for all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset pin, sampled on `clk` |
| sclk | input | 1 | Serial bit clock, slower than `clk` |
| fsync | input | 1 | Frame sync, high during the first bit of a word |
| sdi | input | 1 | Serial data in; also selects the mode while in reset |
| sdo | output | 1 | Serial data out, carries read returns |
| busy | output | 1 | High during reset and the lockout window |
| mem_clear | output | 1 | Sample-memory clear strobe, high for the same window |
| master_mode | output | 1 | Latched master (1) or slave (0) selection |
| reg_data | output | 70 | All registers, register n in bits 10n+9:10n |

## Verification
The bench counts the lockout edge by edge. An off-by-one counter would release `busy` one cycle early or late. It also sends a write and a read while the block is still busy. A design that does not gate on `busy` would change a register or leave a stale read return, which would then show up in the frame after the lockout.

Every address 0 to 7 is written with the reserved bits set. A design that decodes address 5 or 7 as writable, or that lets reserved bits leak into the data, would show the wrong value on `reg_data`.

Each address is then read back with a junk data field, including two reads sent back to back. A return placed one frame late, shifted by a bit, or left unmasked for address 7 gives the wrong captured word.

A final reset after the writes checks that every register returns to its default and that the mode tracks `sdi`.

// File: rtl/cctl_pkg.sv
package cctl_pkg;

  localparam int WORD_W   = 16;
  localparam int DATA_W   = 10;
  localparam int ADDR_W   = 3;
  localparam int RSVD_W   = WORD_W - 1 - ADDR_W - DATA_W;
  localparam int BITCNT_W = $clog2(WORD_W);

  // Control word layout, MSB first on the wire.
  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [RSVD_W-1:0] rsvd;
    logic [DATA_W-1:0] data;
  } ctl_word_t;

  // Register n resets to n*64.
  function automatic logic [DATA_W-1:0] reg_default(input int n);
    return DATA_W'(n * 64);
  endfunction

endpackage

// File: rtl/ctl_reset_seq.sv
module ctl_reset_seq #(
  parameter int RESET_CYCLES = 3072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdi_s,
  output logic busy,
  output logic mem_clear,
  output logic master_mode
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      busy        <= 1'b1;
      mem_clear   <= 1'b1;
      master_mode <= sdi_s;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        busy      <= 1'b0;
        mem_clear <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import cctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              fsync,
  input  logic              sdi,
  input  logic              load_tx,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sdo,
  output logic              sdi_s
);

  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sclk_p, fs_p, sdi_p;
  logic                   sclk_s, fs_s, sclk_d, rise;
  logic                   active;
  logic [BITCNT_W-1:0]    bitcnt;
  logic [WORD_W-1:0]      rx_sh, tx_sh, pending;

  // Pin synchronizers into the master-clock domain.
  always_ff @(posedge clk) begin
    sclk_p[0] <= sclk;
    fs_p[0]   <= fsync;
    sdi_p[0]  <= sdi;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sclk_p[i] <= sclk_p[i-1];
      fs_p[i]   <= fs_p[i-1];
      sdi_p[i]  <= sdi_p[i-1];
    end
    sclk_d <= sclk_s;
  end

  assign sclk_s = sclk_p[SYNC_STAGES-1];
  assign fs_s   = fs_p[SYNC_STAGES-1];
  assign sdi_s  = sdi_p[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      pending   <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (rise) begin
        if (fs_s) begin
          active  <= 1'b1;
          bitcnt  <= BITCNT_W'(1);
          rx_sh   <= {rx_sh[WORD_W-2:0], sdi_s};
          tx_sh   <= pending;
          pending <= '0;
        end else if (active) begin
          rx_sh  <= {rx_sh[WORD_W-2:0], sdi_s};
          tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_BIT) begin
            active    <= 1'b0;
            word_done <= 1'b1;
          end
        end
      end
      if (load_tx) pending <= tx_word;
    end
  end

  assign rx_word = rx_sh;
  assign sdo     = tx_sh[WORD_W-1];

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import cctl_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int RO_INDEX = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic                       word_done,
  input  logic [WORD_W-1:0]          rx_word,
  output logic                       load_tx,
  output logic [WORD_W-1:0]          tx_word,
  output logic [NUM_REGS*DATA_W-1:0] reg_flat
);

  ctl_word_t         w;
  logic              accept;
  logic [DATA_W-1:0] rd_val;

  assign w      = ctl_word_t'(rx_word);
  assign accept = word_done & ~busy;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] r;
    if (g == RO_INDEX) begin : g_ro
      always_ff @(posedge clk) begin
        if (!rst_n) r <= reg_default(g);
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= reg_default(g);
        else if (accept && w.wr && (w.addr == ADDR_W'(g)))
          r <= w.data;
      end
    end
    assign reg_flat[g*DATA_W +: DATA_W] = r;
  end

  // Read mux; addresses without a register return zero.
  always_comb begin
    rd_val = '0;
    for (int n = 0; n < NUM_REGS; n++)
      if (w.addr == ADDR_W'(n)) rd_val = reg_flat[n*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_tx <= 1'b0;
      tx_word <= '0;
    end else begin
      load_tx <= accept & ~w.wr;
      tx_word <= {{(WORD_W-DATA_W){1'b0}}, rd_val};
    end
  end

endmodule

// File: rtl/codec_ctl_top.sv
module codec_ctl_top
  import cctl_pkg::*;
#(
  parameter int RESET_CYCLES = 3072,
  parameter int NUM_REGS     = 7,
  parameter int RO_INDEX     = 5,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       fsync,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       busy,
  output logic                       mem_clear,
  output logic                       master_mode,
  output logic [NUM_REGS*DATA_W-1:0] reg_data
);

  logic              sdi_s, word_done, load_tx;
  logic [WORD_W-1:0] rx_word, tx_word;

  ctl_reset_seq #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .sdi_s(sdi_s),
    .busy(busy), .mem_clear(mem_clear), .master_mode(master_mode)
  );

  ctl_serial_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdi(sdi),
    .load_tx(load_tx), .tx_word(tx_word), .word_done(word_done),
    .rx_word(rx_word), .sdo(sdo), .sdi_s(sdi_s)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .RO_INDEX(RO_INDEX)) u_regs (
    .clk(clk), .rst_n(rst_n), .busy(busy), .word_done(word_done),
    .rx_word(rx_word), .load_tx(load_tx), .tx_word(tx_word),
    .reg_flat(reg_data)
  );

endmodule

// File: rtl/cctl_chk.sv
module cctl_chk
  import cctl_pkg::*;
#(
  parameter int RESET_CYCLES = 3072,
  parameter int NUM_REGS     = 7,
  parameter int RO_INDEX     = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       mem_clear,
  input logic                       master_mode,
  input logic [NUM_REGS*DATA_W-1:0] reg_data
);

  localparam int CW = $clog2(RESET_CYCLES + 1);

  logic [NUM_REGS*DATA_W-1:0] dflt;
  logic [CW-1:0]              since;

  always_comb
    for (int n = 0; n < NUM_REGS; n++) dflt[n*DATA_W +: DATA_W] = reg_default(n);

  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (since != CW'(RESET_CYCLES)) since <= since + 1'b1;
  end

  // R1
  reset_defaults_chk: assert property (@(posedge clk)
    !rst_n |=> (busy && mem_clear && reg_data == dflt));

  // R2
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (since == CW'(RESET_CYCLES)));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since == CW'(RESET_CYCLES)) |-> (!busy && !mem_clear));

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(master_mode));

  // R6
  ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(reg_data[RO_INDEX*DATA_W +: DATA_W]));

  // R10
  busy_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(reg_data));

endmodule

bind codec_ctl_top cctl_chk #(
  .RESET_CYCLES(RESET_CYCLES), .NUM_REGS(NUM_REGS), .RO_INDEX(RO_INDEX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_clear(mem_clear),
  .master_mode(master_mode), .reg_data(reg_data)
);

// File: tb/codec_ctl_test.sv
module codec_ctl_test;

  localparam int RC = 3072;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sclk = 1'b0, fsync = 1'b0, sdi = 1'b1;
  logic sdo, busy, mem_clear, master_mode;
  logic [NR*10-1:0] reg_data;

  int checks = 0, errors = 0;
  logic [9:0] model [NR];

  always #5 clk = ~clk;

  codec_ctl_top uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sdi(sdi),
    .sdo(sdo), .busy(busy), .mem_clear(mem_clear),
    .master_mode(master_mode), .reg_data(reg_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdi = w[i]; fsync = (i == 15); sclk = 1'b0;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      rx[i] = sdo;
    end
    sclk = 1'b0; fsync = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic reset_models();
    for (int n = 0; n < NR; n++) model[n] = 10'(n * 64);
  endtask

  task automatic check_regs(input string req);
    for (int n = 0; n < NR; n++)
      chk(req, 32'(reg_data[n*10 +: 10]), 32'(model[n]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    int cyc;
    reset_models();

    // R1, R3: hold reset with sdi high
    repeat (20) @(negedge clk);
    chk("R1 busy", 32'(busy), 1);
    chk("R1 clear", 32'(mem_clear), 1);
    check_regs("R1 defaults");
    chk("R3 mode high", 32'(master_mode), 1);

    // R2: count the lockout
    @(negedge clk); rst_n = 1'b1; sdi = 1'b0;
    cyc = 0;
    while (busy && cyc < RC + 10) begin
      @(posedge clk); #1; cyc++;
    end
    chk("R2 lockout length", 32'(cyc), 32'(RC));
    chk("R2 clear low", 32'(mem_clear), 0);
    chk("R3 mode holds", 32'(master_mode), 1);

    // R10, R3: second reset with sdi low, access during lockout
    @(negedge clk); rst_n = 1'b0; sdi = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    send_word({1'b1, 3'd0, 2'b00, 10'h155}, rx);
    send_word({1'b0, 3'd2, 2'b00, 10'h000}, rx);
    chk("R10 still busy", 32'(busy), 1);
    check_regs("R10 no write in lockout");
    while (busy) @(negedge clk);
    send_word(16'hF000, rx);
    chk("R10 no read return", 32'(rx), 0);
    chk("R3 mode low", 32'(master_mode), 0);

    // R4-R7, R11: write every address, reserved bits set
    for (int a = 0; a < 8; a++) begin
      logic [9:0] v;
      v = 10'((a * 97 + 13) & 10'h3FF);
      send_word({1'b1, 3'(a), 2'b11, v}, rx);
      chk("R11 zero after write", 32'(rx), 0);
      if (a < NR && a != 5) model[a] = v;
      if (a == 5) check_regs("R6 read-only write");
      else if (a == 7) check_regs("R7 address 7 write");
      else check_regs("R5 write");
    end

    // R8, R9: read every address with a junk data field
    for (int a = 0; a < 8; a++) begin
      send_word({1'b0, 3'(a), 2'b10, 10'h2AA}, rx);
      check_regs("R8 read leaves registers");
      send_word(16'hF000, rx);
      if (a < NR) chk("R8 read return", 32'(rx), 32'(model[a]));
      else chk("R9 read address 7", 32'(rx), 0);
    end

    // R8: back-to-back reads
    send_word({1'b0, 3'd1, 2'b00, 10'h3FF}, rx);
    send_word({1'b0, 3'd3, 2'b00, 10'h3FF}, rx);
    chk("R8 back-to-back first", 32'(rx), 32'(model[1]));
    send_word(16'hF000, rx);
    chk("R8 back-to-back second", 32'(rx), 32'(model[3]));
    send_word(16'hF000, rx);
    chk("R11 zero after non-read", 32'(rx), 0);

    // R1, R3: reset after writes restores defaults
    @(negedge clk); rst_n = 1'b0; sdi = 1'b1;
    repeat (10) @(negedge clk);
    reset_models();
    check_regs("R1 defaults after writes");
    chk("R1 busy again", 32'(busy), 1);
    chk("R3 mode follows sdi", 32'(master_mode), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule